// File: doc/BRIEF.md
# Calibrated Seconds Real-Time Counter

This block keeps a 32-bit count of elapsed seconds for a system that runs from a fast bus clock but has a slow crystal beside it. Each crystal cycle arrives as a one-cycle enable on the bus clock. A programmable divider turns these enables into one-second events. An optional fractional correction stretches a few seconds in every sixteen by one crystal tick, so a crystal whose frequency is not a whole number of hertz still keeps good time.

Software talks to the block through a small register bus with an address, write data, a write strobe, a read strobe and combinational read data. A new time value written to the block is held as pending. It reaches the visible current-time register only on the next one-second event. Writing the calibration word restarts the divider, so the first second after a time change lasts exactly one calibrated period. Each second raises a sticky status flag that software clears by writing a one to it. A control register holds a single battery-enable flag and does not touch the counting path.

Top module: `rtcs_top`

## Requirements
- R1: After reset, every readable location returns zero: current time (0x10), set-time readback (0x04), status (0x20) and control (0x40).
- R2: A write to offset 0x00 is returned by offset 0x04 from the next cycle on. The current time at 0x10 does not change until the next one-second event.
- R3: On a one-second event with a set-time value pending, the current time takes that value and the pending state clears.
- R4: On a one-second event with nothing pending, the current time increases by one and wraps from 0xFFFFFFFF to 0.
- R5: With calibration bit 20 clear, a one-second event fires on every T-th crystal enable, where T is calibration bits [15:0]. Bus-clock cycles without the crystal enable do not advance the divider.
- R6: With calibration bit 20 set and F taken from bits [19:16], the first F seconds of each 16-second window last T+1 enables and the other seconds last T. The window restarts at every calibration write.
- R7: A write to the calibration word at offset 0x08 clears the divider, so the next event comes exactly one full period of enables later. The word resets to 0x198233 (T=0x8233, F=9, correction on), so the first second after reset lasts 33332 enables.
- R8: Status bit 0 at offset 0x20 is set by every one-second event. Writing 1 to it clears it, and writing 0 has no effect. When an event and a clear fall in the same cycle, the bit stays set.
- R9: A set-time write in the same cycle as a one-second event is kept pending. That event applies the earlier content, and the new value is loaded on the following event.
- R10: Control bit 31 at offset 0x40 reads back as written, and all other control bits read zero. Its value does not affect counting.
- R11: Writes to 0x04 and 0x10 are ignored. Reads of 0x00, 0x08 and any unmapped offset return zero, and the read data is zero while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| xtal_en | input | 1 | One-cycle enable per crystal period |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |

## Verification
A one-second event can fall in the same cycle as a set-time write, and also in the same cycle as a write that clears the status flag. The bench steps the divider to one enable short of its period. It then drives the final crystal enable and the bus write in the same clock cycle. For the set-time case, it expects the current time to show only the increment, with the readback already holding the new value, and it expects the new value to appear exactly one period later. For the status case, it expects the flag to read back as set.

// File: rtl/rtcs_pkg.sv
package rtcs_pkg;
  localparam int unsigned OFS_SET_WR = 'h00;
  localparam int unsigned OFS_SET_RD = 'h04;
  localparam int unsigned OFS_CAL    = 'h08;
  localparam int unsigned OFS_CUR    = 'h10;
  localparam int unsigned OFS_STS    = 'h20;
  localparam int unsigned OFS_CTRL   = 'h40;

  localparam int unsigned CTRL_BAT_BIT = 31;
  localparam int unsigned STS_SEC_BIT  = 0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SET_WR,
    SEL_SET_RD,
    SEL_CAL,
    SEL_CUR,
    SEL_STS,
    SEL_CTRL
  } reg_sel_e;
endpackage

// File: rtl/rtcs_rst_sync.sv
module rtcs_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/rtcs_tick_div.sv
module rtcs_tick_div #(
  parameter int unsigned TICK_W = 16,
  parameter int unsigned FRAC_W = 4,
  localparam int unsigned CAL_W = TICK_W + FRAC_W + 1,
  localparam int unsigned CNT_W = TICK_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xtal_en,
  input  logic             cal_wr,
  input  logic [CAL_W-1:0] cal_val,
  output logic             sec_evt
);
  logic [TICK_W-1:0] ticks;
  logic [FRAC_W-1:0] frac;
  logic              frac_on;
  logic              extra;
  logic [CNT_W-1:0]  period;
  logic [CNT_W-1:0]  cnt_inc;
  logic              terminal;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [FRAC_W-1:0] win_q, win_d;
  logic              cnt_en;

  assign ticks   = cal_val[TICK_W-1:0];
  assign frac    = cal_val[TICK_W+FRAC_W-1:TICK_W];
  assign frac_on = cal_val[CAL_W-1];

  always_comb begin
    extra    = frac_on && (win_q < frac);
    period   = CNT_W'(ticks) + CNT_W'(extra);
    cnt_inc  = cnt_q + CNT_W'(1);
    terminal = (cnt_inc >= period);
    sec_evt  = xtal_en && terminal && !cal_wr;
  end

  always_comb begin
    cnt_en = cal_wr || xtal_en;
    cnt_d  = cnt_q;
    win_d  = win_q;
    if (cal_wr) begin
      cnt_d = '0;
      win_d = '0;
    end else if (xtal_en) begin
      if (terminal) begin
        cnt_d = '0;
        win_d = win_q + FRAC_W'(1);
      end else begin
        cnt_d = cnt_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      win_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      win_q <= win_d;
    end
  end

  p_calclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cal_wr |=> (cnt_q == '0) && (win_q == '0));
  p_evt_needs_xtal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |-> xtal_en);
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!xtal_en && !cal_wr) |=> ($stable(cnt_q) && $stable(win_q)));
  p_evt_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> (cnt_q == '0));
endmodule

// File: rtl/rtcs_time_core.sv
module rtcs_time_core #(
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_evt,
  input  logic              set_wr,
  input  logic [TIME_W-1:0] set_data,
  input  logic              sts_clr,
  output logic [TIME_W-1:0] cur_time,
  output logic [TIME_W-1:0] set_time,
  output logic              sec_flag
);
  logic [TIME_W-1:0] cur_q, cur_d;
  logic [TIME_W-1:0] set_q;
  logic              pend_q, pend_d;
  logic              flag_q, flag_d;

  always_comb begin
    cur_d = cur_q;
    if (sec_evt) begin
      if (pend_q) cur_d = set_q;
      else        cur_d = cur_q + TIME_W'(1);
    end
  end

  always_comb begin
    pend_d = pend_q;
    if (set_wr)       pend_d = 1'b1;
    else if (sec_evt) pend_d = 1'b0;
  end

  always_comb begin
    flag_d = flag_q;
    if (sec_evt)      flag_d = 1'b1;
    else if (sts_clr) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (sec_evt)            cur_q  <= cur_d;
      if (set_wr || sec_evt)  pend_q <= pend_d;
      if (sec_evt || sts_clr) flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      set_q <= '0;
    else if (set_wr) set_q <= set_data;
  end

  assign cur_time = cur_q;
  assign set_time = set_q;
  assign sec_flag = flag_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_evt |=> $stable(cur_q));
  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && pend_q) |=> (cur_q == $past(set_q)));
  p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && !pend_q) |=> (cur_q == $past(cur_q) + TIME_W'(1)));
  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> flag_q);
  p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !sec_evt) |=> !flag_q);
  p_pend_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_wr |=> pend_q);
endmodule

// File: rtl/rtcs_bus_if.sv
module rtcs_bus_if
  import rtcs_pkg::*;
#(
  parameter int unsigned    ADDR_W    = 8,
  parameter int unsigned    TIME_W    = 32,
  parameter int unsigned    CAL_W     = 21,
  parameter logic [CAL_W-1:0] CAL_RESET = 21'h198233
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CAL_W-1:0]  wdata_cal,
  input  logic              wdata_bat,
  input  logic              wdata_clr,
  input  logic [TIME_W-1:0] cur_time,
  input  logic [TIME_W-1:0] set_time,
  input  logic              sec_flag,
  output logic              set_wr,
  output logic              cal_wr,
  output logic              sts_clr,
  output logic [CAL_W-1:0]  cal_val,
  output logic [31:0]       bus_rdata
);
  reg_sel_e         sel;
  logic [CAL_W-1:0] cal_q;
  logic             bat_q;
  logic             ctrl_wr;
  logic [31:0]      rd_mux;

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(OFS_SET_WR): sel = SEL_SET_WR;
      ADDR_W'(OFS_SET_RD): sel = SEL_SET_RD;
      ADDR_W'(OFS_CAL):    sel = SEL_CAL;
      ADDR_W'(OFS_CUR):    sel = SEL_CUR;
      ADDR_W'(OFS_STS):    sel = SEL_STS;
      ADDR_W'(OFS_CTRL):   sel = SEL_CTRL;
      default:             sel = SEL_NONE;
    endcase
  end

  always_comb begin
    set_wr  = bus_wr && (sel == SEL_SET_WR);
    cal_wr  = bus_wr && (sel == SEL_CAL);
    ctrl_wr = bus_wr && (sel == SEL_CTRL);
    sts_clr = bus_wr && (sel == SEL_STS) && wdata_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cal_q <= CAL_RESET;
    else if (cal_wr) cal_q <= wdata_cal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bat_q <= 1'b0;
    else if (ctrl_wr) bat_q <= wdata_bat;
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_SET_RD: rd_mux = 32'(set_time);
      SEL_CUR:    rd_mux = 32'(cur_time);
      SEL_STS:    rd_mux[STS_SEC_BIT]  = sec_flag;
      SEL_CTRL:   rd_mux[CTRL_BAT_BIT] = bat_q;
      default:    rd_mux = '0;
    endcase
    bus_rdata = bus_rd ? rd_mux : '0;
  end

  assign cal_val = cal_q;

  p_cal_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_wr |=> $stable(cal_q));
  p_bat_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(bat_q));
  p_onestrobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_wr, cal_wr, ctrl_wr, sts_clr}));
endmodule

// File: rtl/rtcs_top.sv
module rtcs_top #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned TIME_W = 32,
  parameter int unsigned TICK_W = 16,
  parameter int unsigned FRAC_W = 4,
  parameter logic [TICK_W+FRAC_W:0] CAL_RESET = 21'h198233
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xtal_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata
);
  localparam int unsigned CAL_W = TICK_W + FRAC_W + 1;

  logic              rst_n_s;
  logic              sec_evt;
  logic              set_wr, cal_wr, sts_clr;
  logic [CAL_W-1:0]  cal_val;
  logic [TIME_W-1:0] cur_time, set_time;
  logic              sec_flag;

  rtcs_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  rtcs_bus_if #(
    .ADDR_W    (ADDR_W),
    .TIME_W    (TIME_W),
    .CAL_W     (CAL_W),
    .CAL_RESET (CAL_RESET)
  ) u_bus (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .wdata_cal (bus_wdata[CAL_W-1:0]),
    .wdata_bat (bus_wdata[rtcs_pkg::CTRL_BAT_BIT]),
    .wdata_clr (bus_wdata[rtcs_pkg::STS_SEC_BIT]),
    .cur_time  (cur_time),
    .set_time  (set_time),
    .sec_flag  (sec_flag),
    .set_wr    (set_wr),
    .cal_wr    (cal_wr),
    .sts_clr   (sts_clr),
    .cal_val   (cal_val),
    .bus_rdata (bus_rdata)
  );

  rtcs_tick_div #(
    .TICK_W (TICK_W),
    .FRAC_W (FRAC_W)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .xtal_en (xtal_en),
    .cal_wr  (cal_wr),
    .cal_val (cal_val),
    .sec_evt (sec_evt)
  );

  rtcs_time_core #(
    .TIME_W (TIME_W)
  ) u_time (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .sec_evt  (sec_evt),
    .set_wr   (set_wr),
    .set_data (bus_wdata[TIME_W-1:0]),
    .sts_clr  (sts_clr),
    .cur_time (cur_time),
    .set_time (set_time),
    .sec_flag (sec_flag)
  );
endmodule

// File: tb/tb_rtcs_top.sv
`timescale 1ns/1ps
module tb_rtcs_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        xtal_en;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_rdata;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_item_t;

  exp_item_t sb_q[$];

  always #2 clk = ~clk;

  rtcs_top dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .xtal_en   (xtal_en),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata)
  );

  // monitor: pops one expectation per read strobe
  always @(negedge clk) begin
    if (bus_rd && !done) begin
      total++;
      if (sb_q.size() == 0) begin
        bad++;
        $display("FAIL scoreboard: read with no expectation, actual=%h", bus_rdata);
      end else begin
        exp_item_t it;
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic xt(input int n);
    xtal_en = 1'b1;
    repeat (n) step();
    xtal_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    exp_item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = a; bus_rd = 1'b1;
    step();
    bus_rd = 1'b0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      if (sb_q.size() != 0) begin
        total++; bad++;
        $display("FAIL scoreboard: %0d expectations left, actual=0 expected=0", sb_q.size());
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #600000;
    total++; bad++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; xtal_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    bus_wr = 1'b0; bus_rd = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    rd(8'h10, 32'h0, "R1 cur");
    rd(8'h04, 32'h0, "R1 setrd");
    rd(8'h20, 32'h0, "R1 sts");
    rd(8'h40, 32'h0, "R1 ctrl");

    // R7 reset calibration: first second is 33332 enables
    xt(33331);
    rd(8'h10, 32'h0, "R7 default one short");
    rd(8'h20, 32'h0, "R7 no flag yet");
    xt(1);
    rd(8'h10, 32'h1, "R7 default period");
    rd(8'h20, 32'h1, "R8 flag set");

    // R8 clear semantics
    wr(8'h08, 32'd5);
    wr(8'h20, 32'h0);
    rd(8'h20, 32'h1, "R8 write 0 keeps");
    wr(8'h20, 32'h1);
    rd(8'h20, 32'h0, "R8 write 1 clears");

    // R2 / R3 / R4
    wr(8'h00, 32'd100);
    rd(8'h04, 32'd100, "R2 readback");
    rd(8'h10, 32'd1, "R2 cur unchanged");
    xt(4);
    rd(8'h10, 32'd1, "R2 before event");
    xt(1);
    rd(8'h10, 32'd100, "R3 load pending");
    xt(5);
    rd(8'h10, 32'd101, "R4 increment");

    // R5 gaps without enable
    xt(3);
    repeat (10) step();
    xt(1);
    rd(8'h10, 32'd101, "R5 gaps ignored");
    xt(1);
    rd(8'h10, 32'd102, "R5 period with gaps");

    // R7 restart on calibration write
    xt(3);
    wr(8'h08, 32'd5);
    xt(4);
    rd(8'h10, 32'd102, "R7 restart short");
    xt(1);
    rd(8'h10, 32'd103, "R7 restart full");

    // R6 fractional: T=5, F=3, on
    wr(8'h08, (32'd1 << 20) | (32'd3 << 16) | 32'd5);
    xt(5);
    rd(8'h10, 32'd103, "R6 stretched sec0");
    xt(1);
    rd(8'h10, 32'd104, "R6 sec0 done");
    xt(6);
    rd(8'h10, 32'd105, "R6 sec1");
    xt(6);
    rd(8'h10, 32'd106, "R6 sec2");
    xt(5);
    rd(8'h10, 32'd107, "R6 sec3 plain");
    xt(60);
    rd(8'h10, 32'd119, "R6 rest of window");
    xt(5);
    rd(8'h10, 32'd119, "R6 new window stretched");
    xt(1);
    rd(8'h10, 32'd120, "R6 new window sec0");

    // R4 wrap
    wr(8'h08, 32'd5);
    wr(8'h00, 32'hFFFF_FFFF);
    xt(5);
    rd(8'h10, 32'hFFFF_FFFF, "R4 load max");
    xt(5);
    rd(8'h10, 32'h0, "R4 wrap");

    // R9 set write on event cycle
    wr(8'h20, 32'h1);
    xt(4);
    xtal_en = 1'b1; bus_addr = 8'h00; bus_wdata = 32'd500; bus_wr = 1'b1;
    step();
    xtal_en = 1'b0; bus_wr = 1'b0;
    rd(8'h10, 32'd1, "R9 event increments");
    rd(8'h04, 32'd500, "R9 readback");
    xt(4);
    rd(8'h10, 32'd1, "R9 still pending");
    xt(1);
    rd(8'h10, 32'd500, "R9 loaded next event");

    // R8 clear on event cycle
    wr(8'h20, 32'h1);
    rd(8'h20, 32'h0, "R8 cleared");
    xt(4);
    xtal_en = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h1; bus_wr = 1'b1;
    step();
    xtal_en = 1'b0; bus_wr = 1'b0;
    rd(8'h20, 32'h1, "R8 event beats clear");
    rd(8'h10, 32'd501, "R8 time advanced");

    // R10 control
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, 32'h8000_0000, "R10 bat bit only");
    xt(5);
    rd(8'h10, 32'd502, "R10 counting intact");
    wr(8'h40, 32'h0);
    rd(8'h40, 32'h0, "R10 bat cleared");

    // R11 ignored writes and zero reads
    wr(8'h10, 32'h1234);
    rd(8'h10, 32'd502, "R11 cur write ignored");
    wr(8'h04, 32'd7);
    rd(8'h04, 32'd500, "R11 readback write ignored");
    rd(8'h00, 32'h0, "R11 set write reads zero");
    rd(8'h08, 32'h0, "R11 cal reads zero");
    rd(8'h44, 32'h0, "R11 unmapped");
    bus_addr = 8'h10;
    @(negedge clk);
    total++;
    if (bus_rdata !== 32'h0) begin
      bad++;
      $display("FAIL R11 idle rdata: actual=%h expected=%h", bus_rdata, 32'h0);
    end
    step();
    finish_up();
  end
endmodule